// File: doc/BRIEF.md
# Reset and Hardware Power-Down Qualifier

This block turns two slow, active-low board inputs into clean internal control. The first is the reset pin and the second is the hardware power-down pin. It also produces a CPU-running status line. Each input passes through a two-flop synchroniser. After that, a saturating duration counter measures how many oscillator clocks the input has stayed low, and the count decides what happens. A reset-pin low must last at least two machine cycles before it resets the device. The power-down pin behaves in two ways. A low of one machine cycle resets the device. A longer low puts the device into hardware power-down and floats the pins.

Internal reset is always released on a machine-cycle strobe. After a hardware power-down, the release waits one extra machine cycle. At the moment reset ends, the block latches the power-save strap pin. A high strap starts the watchdog automatically and blocks the software power-saving modes. A low strap leaves the watchdog off and permits those modes. The latched values hold until the next reset ends.

Top module: `rst_pd_qualifier`

## Requirements
- R1: Once synchronised, `rst_pin_n` must be low for at least 12 consecutive oscillator clocks (two machine cycles of six clocks) before `sys_rst` asserts. A low of 11 clocks or fewer leaves `sys_rst` at 0.
- R2: `sys_rst` stays high while either input pin is low. After both pins are high again, it falls at the first edge where `mc_stb` is high. After the reset pin is raised, this takes 4 to 9 clocks with a strobe every six clocks.
- R3: A low on `hwpd_pin_n` of exactly 6 clocks (one machine cycle) asserts `sys_rst` but not `hw_pd`. A low of 5 clocks or fewer has no effect on either output.
- R4: A low on `hwpd_pin_n` of 7 clocks or more asserts `hw_pd`, `pins_float` and `sys_rst`. All three stay high while the pin stays low, and `pins_float` is never high without `sys_rst`.
- R5: When `hwpd_pin_n` returns high after a power-down, `hw_pd` and `pins_float` clear. `sys_rst` then stays high until the second strobe counted from the clock where `hw_pd` fell, which is 6 to 11 clocks later.
- R6: At the clock where `sys_rst` falls, `wdt_autostart` takes the synchronised `pe_strap` level and `sw_pd_allowed` takes its inverse. Both then hold, whatever `pe_strap` does, until `sys_rst` next falls.
- R7: `cpur_n` is 1 whenever `sys_rst`, `hw_pd`, `idle_st` or `swpd_st` is high, and 0 otherwise. It follows these signals one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| mc_stb | input | 1 | One-clock strobe, once per machine cycle |
| rst_pin_n | input | 1 | Asynchronous reset pin, active low |
| hwpd_pin_n | input | 1 | Asynchronous hardware power-down pin, active low |
| pe_strap | input | 1 | Power-save enable / watchdog start strap pin |
| idle_st | input | 1 | CPU is in idle mode |
| swpd_st | input | 1 | CPU is in software power-down |
| sys_rst | output | 1 | Internal device reset, active high |
| hw_pd | output | 1 | Hardware power-down request |
| pins_float | output | 1 | Tri-state enable for all port drivers |
| wdt_autostart | output | 1 | Watchdog starts immediately after reset |
| sw_pd_allowed | output | 1 | Software power-saving modes may be entered |
| cpur_n | output | 1 | CPU running status, low while running |

## Verification
The reset pin is pulsed for 11 and then 12 clocks, which separates a glitch from a qualified reset exactly at the threshold. The power-down pin is pulsed for 5, 6 and 7 clocks. These three lengths separate no effect, a reset only, and a power-down. A long power-down followed by release measures the reset stretch in strobe periods. A long reset followed by release does the same for the plain release path. The strap is flipped both before and after releases, which shows that it is sampled only when reset ends. Idle and software power-down are then raised one at a time to check the running status.

// File: rtl/rpq_pkg.sv
package rpq_pkg;

  typedef enum logic [1:0] {
    PH_RUN = 2'd0,
    PH_RST = 2'd1,
    PH_PD  = 2'd2
  } phase_e;

  // clocks covered by a number of machine cycles
  function automatic int unsigned mc_to_clks(int unsigned mcs, int unsigned per_mc);
    return mcs * per_mc;
  endfunction

  // a power-down needs strictly more than the reset window
  function automatic int unsigned beyond(int unsigned clks);
    return clks + 1;
  endfunction

  // strobes to wait before release: one, plus the stretch
  function automatic int unsigned release_strobes(int unsigned stretch_mc);
    return stretch_mc + 1;
  endfunction

endpackage

// File: rtl/rpq_sync.sv
module rpq_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : st
      logic [W-1:0] r;
      if (g == 0) begin : first
        always_ff @(posedge clk) r <= d;
      end else begin : chain
        always_ff @(posedge clk) r <= st[g-1].r;
      end
    end
  endgenerate

  assign q = st[STAGES-1].r;

endmodule

// File: rtl/rpq_lowtimer.sv
module rpq_lowtimer #(
  parameter int unsigned THR_SHORT = 6,
  parameter int unsigned THR_LONG  = 7
) (
  input  logic clk,
  input  logic lvl,
  output logic hit_short,
  output logic hit_long
);

  localparam int unsigned CMAX = (THR_LONG > THR_SHORT) ? THR_LONG : THR_SHORT;
  localparam int unsigned CW   = $clog2(CMAX + 1);

  logic [CW-1:0] cnt;

  // restarts whenever the level is high, saturates at CMAX
  always_ff @(posedge clk) begin
    if (lvl)                    cnt <= '0;
    else if (cnt != CW'(CMAX))  cnt <= cnt + 1'b1;
  end

  assign hit_short = (cnt >= CW'(THR_SHORT));
  assign hit_long  = (cnt >= CW'(THR_LONG));

endmodule

// File: rtl/rpq_ctrl.sv
module rpq_ctrl
  import rpq_pkg::*;
#(
  parameter int unsigned REL_STROBES = 2
) (
  input  logic   clk,
  input  logic   mc_stb,
  input  logic   rst_lvl,
  input  logic   hwpd_lvl,
  input  logic   rst_hit,
  input  logic   hwpd_hit,
  input  logic   hwpd_long,
  output phase_e phase,
  output logic   rel_fire
);

  localparam int unsigned RCW = $clog2(REL_STROBES + 1);

  logic [RCW-1:0] rel_cnt;
  logic           stretch;
  logic           any_low;
  logic           any_hit;
  logic [RCW-1:0] need_m1;

  assign any_low  = !rst_lvl || !hwpd_lvl;
  assign any_hit  = rst_hit || hwpd_hit || hwpd_long;
  assign need_m1  = stretch ? RCW'(REL_STROBES - 1) : '0;
  assign rel_fire = (phase != PH_RUN) && !any_hit && !any_low && mc_stb
                    && (rel_cnt == need_m1);

  always_ff @(posedge clk) begin
    if (hwpd_long) begin
      phase   <= PH_PD;
      stretch <= 1'b1;
      rel_cnt <= '0;
    end else if (any_hit) begin
      if (phase == PH_RUN) phase <= PH_RST;
      rel_cnt <= '0;
    end else begin
      if (rel_fire) begin
        phase   <= PH_RUN;
        stretch <= 1'b0;
        rel_cnt <= '0;
      end else begin
        if (phase == PH_PD && hwpd_lvl) phase <= PH_RST;
        if (phase != PH_RUN && !any_low && mc_stb) rel_cnt <= rel_cnt + 1'b1;
        else if (any_low)                          rel_cnt <= '0;
      end
    end
  end

  // R4: entry into power-down only after a long low on the power-down pin
  assert_pd_needs_long_R4: assert property (@(posedge clk) disable iff (!rst_lvl)
    (phase == PH_PD && $past(phase) != PH_PD) |-> $past(hwpd_long));

  // R5: leaving power-down always passes through reset, never straight to run
  assert_pd_exit_to_reset_R5: assert property (@(posedge clk) disable iff (!rst_lvl)
    ($past(phase) == PH_PD && phase != PH_PD) |-> (phase == PH_RST));

endmodule

// File: rtl/rst_pd_qualifier.sv
module rst_pd_qualifier
  import rpq_pkg::*;
#(
  parameter int unsigned OSC_PER_MC    = 6,
  parameter int unsigned RST_LOW_MC    = 2,
  parameter int unsigned HWPD_RST_MC   = 1,
  parameter int unsigned PD_STRETCH_MC = 1,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic mc_stb,
  input  logic rst_pin_n,
  input  logic hwpd_pin_n,
  input  logic pe_strap,
  input  logic idle_st,
  input  logic swpd_st,
  output logic sys_rst,
  output logic hw_pd,
  output logic pins_float,
  output logic wdt_autostart,
  output logic sw_pd_allowed,
  output logic cpur_n
);

  localparam int unsigned RST_THR     = mc_to_clks(RST_LOW_MC, OSC_PER_MC);
  localparam int unsigned HWPD_RST_TH = mc_to_clks(HWPD_RST_MC, OSC_PER_MC);
  localparam int unsigned HWPD_PD_TH  = beyond(HWPD_RST_TH);
  localparam int unsigned REL_STB     = release_strobes(PD_STRETCH_MC);

  logic [2:0] pin_raw, pin_sync;
  logic       rst_lvl, hwpd_lvl, pe_lvl;
  logic       rst_hit, rst_hit_l;
  logic       hwpd_hit, hwpd_long;
  logic       rel_fire;
  phase_e     phase;

  assign pin_raw = {pe_strap, hwpd_pin_n, rst_pin_n};

  rpq_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (pin_raw),
    .q   (pin_sync)
  );

  assign rst_lvl  = pin_sync[0];
  assign hwpd_lvl = pin_sync[1];
  assign pe_lvl   = pin_sync[2];

  rpq_lowtimer #(.THR_SHORT(RST_THR), .THR_LONG(RST_THR)) u_rst_tmr (
    .clk       (clk),
    .lvl       (rst_lvl),
    .hit_short (rst_hit),
    .hit_long  (rst_hit_l)
  );

  rpq_lowtimer #(.THR_SHORT(HWPD_RST_TH), .THR_LONG(HWPD_PD_TH)) u_hwpd_tmr (
    .clk       (clk),
    .lvl       (hwpd_lvl),
    .hit_short (hwpd_hit),
    .hit_long  (hwpd_long)
  );

  rpq_ctrl #(.REL_STROBES(REL_STB)) u_ctrl (
    .clk       (clk),
    .mc_stb    (mc_stb),
    .rst_lvl   (rst_lvl),
    .hwpd_lvl  (hwpd_lvl),
    .rst_hit   (rst_hit | rst_hit_l),
    .hwpd_hit  (hwpd_hit),
    .hwpd_long (hwpd_long),
    .phase     (phase),
    .rel_fire  (rel_fire)
  );

  assign sys_rst = (phase != PH_RUN);
  assign hw_pd   = (phase == PH_PD);

  // strap captured only at the clock that ends reset
  always_ff @(posedge clk) begin
    if (rel_fire) begin
      wdt_autostart <= pe_lvl;
      sw_pd_allowed <= !pe_lvl;
    end
  end

  always_ff @(posedge clk) begin
    pins_float <= hw_pd;
    cpur_n     <= sys_rst | hw_pd | idle_st | swpd_st;
  end

  // R4: floating pins only while the device is held in reset
  assert_float_implies_reset_R4: assert property (@(posedge clk) disable iff (!rst_pin_n)
    pins_float |-> sys_rst);

  // R2: reset is released only on a machine-cycle strobe
  assert_release_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(sys_rst) |-> $past(mc_stb));

  // R6: strap outputs frozen while running
  assert_strap_hold_R6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (!sys_rst && !$past(sys_rst)) |-> ($stable(wdt_autostart) && $stable(sw_pd_allowed)));

  // R7: a low-power status forces the running line high on the next clock
  assert_cpur_lowpower_R7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (idle_st || swpd_st || hw_pd) |=> cpur_n);

endmodule

// File: tb/rst_pd_qualifier_test.sv
module rst_pd_qualifier_test;

  logic clk = 1'b0;
  logic mc_stb = 1'b0;
  logic rst_pin_n = 1'b0;
  logic hwpd_pin_n = 1'b1;
  logic pe_strap = 1'b1;
  logic idle_st = 1'b0;
  logic swpd_st = 1'b0;
  logic sys_rst, hw_pd, pins_float, wdt_autostart, sw_pd_allowed, cpur_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit seen_rst = 1'b0;
  bit seen_pd  = 1'b0;

  typedef struct {
    string req;
    string what;
    int    got;
    int    lo;
    int    hi;
  } sb_item_t;

  sb_item_t sb_q[$];

  always #5 clk = ~clk;

  rst_pd_qualifier uut (
    .clk(clk), .mc_stb(mc_stb), .rst_pin_n(rst_pin_n), .hwpd_pin_n(hwpd_pin_n),
    .pe_strap(pe_strap), .idle_st(idle_st), .swpd_st(swpd_st),
    .sys_rst(sys_rst), .hw_pd(hw_pd), .pins_float(pins_float),
    .wdt_autostart(wdt_autostart), .sw_pd_allowed(sw_pd_allowed), .cpur_n(cpur_n)
  );

  // machine-cycle strobe: one clock in six
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 6;
      mc_stb = (ph == 0);
    end
  end

  // sticky observers
  initial forever begin
    @(negedge clk);
    if (sys_rst) seen_rst = 1'b1;
    if (hw_pd)   seen_pd  = 1'b1;
  end

  // monitor: pops expectations and compares
  initial forever begin
    @(negedge clk);
    while (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      n_tests++;
      if (it.got < it.lo || it.got > it.hi) begin
        n_fail++;
        $display("FAIL %s %s: actual %0d expected %0d..%0d", it.req, it.what, it.got, it.lo, it.hi);
      end
    end
  end

  task automatic expect_rng(string req, string what, int got, int lo, int hi);
    sb_item_t it;
    it.req = req; it.what = what; it.got = got; it.lo = lo; it.hi = hi;
    sb_q.push_back(it);
  endtask

  task automatic expect_eq(string req, string what, int got, int exp);
    expect_rng(req, what, got, exp, exp);
  endtask

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rst(int len);
    @(negedge clk);
    seen_rst = 1'b0; seen_pd = 1'b0;
    rst_pin_n = 1'b0;
    repeat (len) @(negedge clk);
    rst_pin_n = 1'b1;
    wait_clks(30);
  endtask

  task automatic pulse_hwpd(int len);
    @(negedge clk);
    seen_rst = 1'b0; seen_pd = 1'b0;
    hwpd_pin_n = 1'b0;
    repeat (len) @(negedge clk);
    hwpd_pin_n = 1'b1;
    wait_clks(30);
  endtask

  initial begin
    int k;
    int t_pd;
    // reset state while the pin is held low
    wait_clks(40);
    expect_eq("R1", "sys_rst held", int'(sys_rst), 1);
    expect_eq("R7", "cpur_n in reset", int'(cpur_n), 1);
    expect_eq("R4", "pins_float in reset", int'(pins_float), 0);

    // release with strap high
    rst_pin_n = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (sys_rst && k < 50);
    expect_rng("R2", "release delay", k, 4, 9);
    wait_clks(3);
    expect_eq("R6", "wdt_autostart strap high", int'(wdt_autostart), 1);
    expect_eq("R6", "sw_pd_allowed strap high", int'(sw_pd_allowed), 0);
    expect_eq("R7", "cpur_n running", int'(cpur_n), 0);

    // strap change while running is ignored
    pe_strap = 1'b0;
    wait_clks(10);
    expect_eq("R6", "wdt_autostart held", int'(wdt_autostart), 1);
    expect_eq("R6", "sw_pd_allowed held", int'(sw_pd_allowed), 0);

    // reset-pin threshold
    pulse_rst(11);
    expect_eq("R1", "11-clock low ignored", int'(seen_rst), 0);
    expect_eq("R6", "strap not relatched", int'(wdt_autostart), 1);
    pulse_rst(12);
    expect_eq("R1", "12-clock low resets", int'(seen_rst), 1);
    expect_eq("R6", "wdt_autostart strap low", int'(wdt_autostart), 0);
    expect_eq("R6", "sw_pd_allowed strap low", int'(sw_pd_allowed), 1);

    // power-down pin thresholds
    pulse_hwpd(5);
    expect_eq("R3", "5-clock low no reset", int'(seen_rst), 0);
    expect_eq("R3", "5-clock low no pd", int'(seen_pd), 0);
    pulse_hwpd(6);
    expect_eq("R3", "6-clock low resets", int'(seen_rst), 1);
    expect_eq("R3", "6-clock low no pd", int'(seen_pd), 0);
    pulse_hwpd(7);
    expect_eq("R4", "7-clock low enters pd", int'(seen_pd), 1);

    // long power-down
    @(negedge clk);
    hwpd_pin_n = 1'b0;
    wait_clks(40);
    expect_eq("R4", "hw_pd held", int'(hw_pd), 1);
    expect_eq("R4", "pins_float held", int'(pins_float), 1);
    expect_eq("R4", "sys_rst held in pd", int'(sys_rst), 1);
    expect_eq("R7", "cpur_n in pd", int'(cpur_n), 1);
    hwpd_pin_n = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (hw_pd && k < 50);
    t_pd = k;
    do begin @(negedge clk); k++; end while (sys_rst && k < 80);
    expect_rng("R5", "reset stretch after pd", k - t_pd, 6, 11);
    expect_eq("R5", "pins_float released", int'(pins_float), 0);

    // running status
    idle_st = 1'b1; wait_clks(3);
    expect_eq("R7", "cpur_n idle", int'(cpur_n), 1);
    idle_st = 1'b0; wait_clks(3);
    expect_eq("R7", "cpur_n back to run", int'(cpur_n), 0);
    swpd_st = 1'b1; wait_clks(3);
    expect_eq("R7", "cpur_n sw power-down", int'(cpur_n), 1);
    swpd_st = 1'b0; wait_clks(3);

    // long reset and plain release timing, strap high again
    pe_strap = 1'b1;
    @(negedge clk);
    rst_pin_n = 1'b0;
    wait_clks(30);
    rst_pin_n = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (sys_rst && k < 50);
    expect_rng("R2", "release after long reset", k, 4, 9);
    wait_clks(3);
    expect_eq("R6", "wdt_autostart relatched", int'(wdt_autostart), 1);

    wait_clks(5);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule